// File: doc/BRIEF.md
# Tagged Token Matching Unit

This block sits between the token network and instruction fetch of a dataflow processor. Each arriving token names a destination instruction and carries a context made of a code block number and an iteration number. The unit collects tokens that name the same instruction in the same context. Once an instruction has all of its operands for one context, the unit sends out a single enabled packet. Because the context is part of the match key, many activations of one instruction can be waiting at the same time without mixing their operands.

A 16-entry instruction table holds three things for each instruction: how many inputs it takes (one or two), whether it has a resident constant operand, and the value of that constant. Software loads the table through a write port before any token traffic starts. Tokens that cannot fire yet wait in an eight-entry associative store. The lookup key is the instruction number, code block and iteration together. A stored token is removed when its partner arrives.

Both data streams use valid/ready. A token is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low in either of two cases: the output register holds a packet that is not being taken on this cycle, or the store is full and the presented token would need a store entry. A packet that is offered on the output stays unchanged until `out_ready` takes it.

Top module: `mu_match_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the token store is empty.
- R2: A token for a single-input instruction (table bit two_in = 0) is never stored. On the clock edge after it is accepted, it appears at the output with `out_op0` = token value, `out_op1` = 0, and the tag fields of the token.
- R3: For a two-input instruction without a constant, the first token of a context produces no output and is stored. The partner token for the same context fires one packet on the edge after it is accepted.
- R4: Operands in the output are ordered by port: `out_op0` holds the port-0 operand and `out_op1` holds the port-1 operand, whichever of the two tokens arrived first.
- R5: Tokens match only when instruction, code block and iteration are all equal. A token that differs from a stored one in any one of these fields is stored separately.
- R6: A token for a two-input instruction that has a constant fires at once. The constant takes the port opposite the token. The constant is not used up, so every later token for that instruction fires with it too.
- R7: When all 8 store entries hold tokens, `in_ready` is 0 for a token that would need storing. It stays 1 for a token that fires: a matching partner, a single-input token, or a token for an instruction with a constant.
- R8: While `out_valid` = 1 and `out_ready` = 0, the output packet stays stable and `in_ready` is 0. If `out_ready` = 1 in the same cycle, a new token can be accepted.
- R9: A configuration write replaces that instruction's input count, constant flag and constant value. Tokens accepted after the write use the new values.
- R10: Reset discards every stored token. The table returns to two-input, no constant for every instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Instruction table write strobe |
| cfg_addr | input | 4 | Instruction number to write |
| cfg_two_in | input | 1 | 1 = instruction takes two inputs, 0 = one input |
| cfg_has_const | input | 1 | Instruction has a resident constant |
| cfg_const | input | 16 | Constant operand value |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Token can be taken this cycle |
| in_instr | input | 4 | Destination instruction |
| in_cb | input | 4 | Code block number |
| in_iter | input | 4 | Iteration number |
| in_port | input | 1 | Input port of destination (0 or 1) |
| in_value | input | 16 | Token value |
| out_valid | output | 1 | Enabled packet offered |
| out_ready | input | 1 | Consumer takes packet |
| out_instr | output | 4 | Instruction of enabled packet |
| out_cb | output | 4 | Code block of enabled packet |
| out_iter | output | 4 | Iteration of enabled packet |
| out_op0 | output | 16 | Port-0 operand |
| out_op1 | output | 16 | Port-1 operand |

## Verification
The hardest state to reach from the ports is a full store together with a token that can still go through. The stimulus fills all eight entries with unmatched port-0 tokens for one instruction, using eight different iteration numbers. It then offers an unrelated ninth token and confirms that `in_ready` stays low for it. Next it swaps the offer to the port-1 partner of a middle entry and confirms that this token is accepted and pairs with the right stored value. Separate cases cover contexts that differ in only one tag field, and a stalled output while tokens are still being offered.

// File: rtl/mu_pkg.sv
package mu_pkg;
  // What an accepted token does this cycle
  typedef enum logic [1:0] {
    ACT_STORE = 2'd0,  // wait for partner
    ACT_PASS  = 2'd1,  // single-input, fire alone
    ACT_CONST = 2'd2,  // fire with resident constant
    ACT_PAIR  = 2'd3   // fire with stored partner
  } mu_action_e;
endpackage

// File: rtl/mu_instr_table.sv
module mu_instr_table #(
  parameter int unsigned N_INSTR = 16,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned IA_W   = $clog2(N_INSTR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IA_W-1:0]   wr_addr,
  input  logic              wr_two_in,
  input  logic              wr_has_const,
  input  logic [DATA_W-1:0] wr_const,
  input  logic [IA_W-1:0]   rd_addr,
  output logic              rd_two_in,
  output logic              rd_has_const,
  output logic [DATA_W-1:0] rd_const
);
  logic [N_INSTR-1:0] two_in_q;
  logic [N_INSTR-1:0] has_const_q;
  logic [DATA_W-1:0]  const_q [N_INSTR];

  for (genvar g = 0; g < N_INSTR; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        two_in_q[g]    <= 1'b1;
        has_const_q[g] <= 1'b0;
        const_q[g]     <= '0;
      end else if (wr_en && wr_addr == IA_W'(g)) begin
        two_in_q[g]    <= wr_two_in;
        has_const_q[g] <= wr_has_const;
        const_q[g]     <= wr_const;
      end
    end
  end

  assign rd_two_in    = two_in_q[rd_addr];
  assign rd_has_const = has_const_q[rd_addr];
  assign rd_const     = const_q[rd_addr];
endmodule

// File: rtl/mu_token_store.sv
module mu_token_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned KEY_W  = 12,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEY_W-1:0]  key,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_value,
  input  logic              rm_en,
  output logic              hit,
  output logic [DEPTH-1:0]  hit_vec,
  output logic [DATA_W-1:0] hit_value,
  output logic              full
);
  logic [DEPTH-1:0]  vld;
  logic [KEY_W-1:0]  keys [DEPTH];
  logic [DATA_W-1:0] vals [DEPTH];
  logic [IDX_W-1:0]  free_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign hit_vec[g] = vld[g] && (keys[g] == key);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld[g] <= 1'b0;
      end else if (wr_en && !vld[g] && free_idx == IDX_W'(g)) begin
        vld[g] <= 1'b1;
      end else if (rm_en && hit_vec[g]) begin
        vld[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && !vld[g] && free_idx == IDX_W'(g)) begin
        keys[g] <= key;
        vals[g] <= wr_value;
      end
    end
  end

  always_comb begin
    free_idx  = '0;
    hit_value = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_value = hit_value | vals[i];
    end
  end

  assign hit  = |hit_vec;
  assign full = &vld;
endmodule

// File: rtl/mu_out_stage.sv
module mu_out_stage #(
  parameter int unsigned W = 44
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         free,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= load_data;
  end
endmodule

// File: rtl/mu_match_unit.sv
module mu_match_unit #(
  parameter int unsigned N_INSTR     = 16,
  parameter int unsigned STORE_DEPTH = 8,
  parameter int unsigned CB_W        = 4,
  parameter int unsigned IT_W        = 4,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned IA_W       = $clog2(N_INSTR),
  localparam int unsigned KEY_W      = IA_W + CB_W + IT_W,
  localparam int unsigned PKT_W      = KEY_W + 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IA_W-1:0]   cfg_addr,
  input  logic              cfg_two_in,
  input  logic              cfg_has_const,
  input  logic [DATA_W-1:0] cfg_const,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IA_W-1:0]   in_instr,
  input  logic [CB_W-1:0]   in_cb,
  input  logic [IT_W-1:0]   in_iter,
  input  logic              in_port,
  input  logic [DATA_W-1:0] in_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IA_W-1:0]   out_instr,
  output logic [CB_W-1:0]   out_cb,
  output logic [IT_W-1:0]   out_iter,
  output logic [DATA_W-1:0] out_op0,
  output logic [DATA_W-1:0] out_op1
);
  import mu_pkg::*;

  logic              tbl_two_in, tbl_has_const;
  logic [DATA_W-1:0] tbl_const;
  logic [KEY_W-1:0]  key;
  logic              st_hit, st_full;
  logic [STORE_DEPTH-1:0] st_hit_vec;
  logic [DATA_W-1:0] st_value;
  logic              out_free, acc, fires;
  mu_action_e        act;
  logic [DATA_W-1:0] partner, op0, op1;
  logic [PKT_W-1:0]  pkt_in, pkt_out;

  assign key = {in_instr, in_cb, in_iter};

  mu_instr_table #(.N_INSTR(N_INSTR), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_two_in(cfg_two_in),
    .wr_has_const(cfg_has_const), .wr_const(cfg_const),
    .rd_addr(in_instr), .rd_two_in(tbl_two_in),
    .rd_has_const(tbl_has_const), .rd_const(tbl_const)
  );

  always_comb begin
    if (!tbl_two_in)        act = ACT_PASS;
    else if (tbl_has_const) act = ACT_CONST;
    else if (st_hit)        act = ACT_PAIR;
    else                    act = ACT_STORE;
  end

  assign fires    = (act != ACT_STORE);
  assign in_ready = out_free && (fires || !st_full);
  assign acc      = in_valid && in_ready;

  mu_token_store #(.DEPTH(STORE_DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .key(key),
    .wr_en(acc && act == ACT_STORE), .wr_value(in_value),
    .rm_en(acc && act == ACT_PAIR),
    .hit(st_hit), .hit_vec(st_hit_vec), .hit_value(st_value), .full(st_full)
  );

  // Operand placement by port; single-input tokens always go to op0
  always_comb begin
    partner = (act == ACT_CONST) ? tbl_const : st_value;
    if (act == ACT_PASS) begin
      op0 = in_value;
      op1 = '0;
    end else if (in_port) begin
      op0 = partner;
      op1 = in_value;
    end else begin
      op0 = in_value;
      op1 = partner;
    end
  end

  assign pkt_in = {key, op0, op1};

  mu_out_stage #(.W(PKT_W)) u_out (
    .clk(clk), .rst(rst), .load(acc && fires), .load_data(pkt_in),
    .free(out_free), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(pkt_out)
  );

  assign {out_instr, out_cb, out_iter, out_op0, out_op1} = pkt_out;
endmodule

// File: rtl/mu_match_checker.sv
module mu_match_checker #(
  parameter int unsigned PKT_W = 44,
  parameter int unsigned DEPTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PKT_W-1:0] pkt,
  input logic [1:0]       act,
  input logic [DEPTH-1:0] hit_vec,
  input logic             full
);
  import mu_pkg::*;
  logic acc;
  assign acc = in_valid && in_ready;

  AST_PASS_FIRES: assert property (@(posedge clk) disable iff (rst)
    acc && act == ACT_PASS |=> out_valid); // R2
  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (rst)
    acc && act == ACT_STORE |=> !out_valid); // R3
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R5
  AST_CONST_FIRES: assert property (@(posedge clk) disable iff (rst)
    acc && act == ACT_CONST |=> out_valid); // R6
  AST_FULL_GATE: assert property (@(posedge clk) disable iff (rst)
    full && act == ACT_STORE |-> !in_ready); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(pkt)); // R8
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R8
endmodule

bind mu_match_unit mu_match_checker #(.PKT_W(PKT_W), .DEPTH(STORE_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .pkt(pkt_out),
  .act(act), .hit_vec(st_hit_vec), .full(st_full)
);

// File: tb/mu_match_unit_tb.sv
module mu_match_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_two_in = 1'b1, cfg_has_const = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_const = '0;
  logic        in_valid = 1'b0, in_port = 1'b0, out_ready = 1'b1;
  logic [3:0]  in_instr = '0, in_cb = '0, in_iter = '0;
  logic [15:0] in_value = '0;
  logic        in_ready, out_valid;
  logic [3:0]  out_instr, out_cb, out_iter;
  logic [15:0] out_op0, out_op1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mu_match_unit dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_two_in(cfg_two_in), .cfg_has_const(cfg_has_const), .cfg_const(cfg_const),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr), .in_cb(in_cb),
    .in_iter(in_iter), .in_port(in_port), .in_value(in_value),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .out_cb(out_cb), .out_iter(out_iter), .out_op0(out_op0), .out_op1(out_op1)
  );

  typedef struct packed {
    logic [3:0]  instr, cb, iter;
    logic        port;
    logic [15:0] val;
    logic        fire;
    logic [15:0] op0, op1;
  } vec_t;

  // instr 1: single input; instr 3: constant 0x0077; others: two inputs
  localparam vec_t VECS [11] = '{
    '{4'd1, 4'd0, 4'd0, 1'b0, 16'h0011, 1'b1, 16'h0011, 16'h0000}, // R2
    '{4'd2, 4'd1, 4'd2, 1'b1, 16'h00B1, 1'b0, 16'h0000, 16'h0000}, // R3
    '{4'd2, 4'd1, 4'd3, 1'b0, 16'h00C0, 1'b0, 16'h0000, 16'h0000}, // R5 iter
    '{4'd2, 4'd2, 4'd2, 1'b0, 16'h00D0, 1'b0, 16'h0000, 16'h0000}, // R5 cb
    '{4'd2, 4'd1, 4'd2, 1'b0, 16'h00A0, 1'b1, 16'h00A0, 16'h00B1}, // R4
    '{4'd2, 4'd1, 4'd3, 1'b1, 16'h00C1, 1'b1, 16'h00C0, 16'h00C1}, // R3
    '{4'd4, 4'd2, 4'd2, 1'b1, 16'h00E1, 1'b0, 16'h0000, 16'h0000}, // R5 instr
    '{4'd2, 4'd2, 4'd2, 1'b1, 16'h00D1, 1'b1, 16'h00D0, 16'h00D1}, // R5
    '{4'd4, 4'd2, 4'd2, 1'b0, 16'h00E0, 1'b1, 16'h00E0, 16'h00E1}, // R4
    '{4'd3, 4'd0, 4'd1, 1'b1, 16'h0031, 1'b1, 16'h0077, 16'h0031}, // R6
    '{4'd3, 4'd5, 4'd6, 1'b0, 16'h0030, 1'b1, 16'h0030, 16'h0077}  // R6
  };

  task automatic check(string req, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
    end
  endtask

  task automatic cfg(logic [3:0] a, logic two, logic hc, logic [15:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_two_in = two; cfg_has_const = hc; cfg_const = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(logic [3:0] i, logic [3:0] c, logic [3:0] t, logic p, logic [15:0] v);
    in_instr = i; in_cb = c; in_iter = t; in_port = p; in_value = v;
  endtask

  // Offer a token at a falling edge, accept at the next rising edge, sample after
  task automatic send(logic [3:0] i, logic [3:0] c, logic [3:0] t, logic p, logic [15:0] v);
    @(negedge clk);
    drive(i, c, t, p, v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 in_ready", 32'(in_ready), 32'd1);

    cfg(4'd1, 1'b0, 1'b0, 16'h0000);
    cfg(4'd3, 1'b1, 1'b1, 16'h0077);

    foreach (VECS[k]) begin
      send(VECS[k].instr, VECS[k].cb, VECS[k].iter, VECS[k].port, VECS[k].val);
      check($sformatf("R3 fire vec%0d", k), 32'(out_valid), 32'(VECS[k].fire));
      if (VECS[k].fire) begin
        check($sformatf("R4 op0 vec%0d", k), 32'(out_op0), 32'(VECS[k].op0));
        check($sformatf("R4 op1 vec%0d", k), 32'(out_op1), 32'(VECS[k].op1));
        check($sformatf("R5 tag vec%0d", k), {20'd0, out_instr, out_cb, out_iter},
              {20'd0, VECS[k].instr, VECS[k].cb, VECS[k].iter});
      end
    end

    // R7: fill store with eight unmatched tokens
    for (int t = 0; t < 8; t++) send(4'd5, 4'd0, 4'(t), 1'b0, 16'h0500 + 16'(t));
    @(negedge clk);
    drive(4'd5, 4'd0, 4'd8, 1'b0, 16'h0508);
    in_valid = 1'b1;
    #1 check("R7 full blocks", 32'(in_ready), 32'd0);
    @(negedge clk);
    check("R7 no output", 32'(out_valid), 32'd0);
    drive(4'd5, 4'd0, 4'd3, 1'b1, 16'h0533);
    #1 check("R7 partner ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 partner fires", 32'(out_valid), 32'd1);
    check("R7 op0", 32'(out_op0), 32'h0503);
    check("R7 op1", 32'(out_op1), 32'h0533);
    send(4'd5, 4'd0, 4'd8, 1'b0, 16'h0508);
    check("R7 slot reused", 32'(out_valid), 32'd0);
    @(negedge clk);
    drive(4'd1, 4'd0, 4'd0, 1'b0, 16'h0111);
    in_valid = 1'b1;
    #1 check("R7 pass while full", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 pass out", 32'(out_op0), 32'h0111);

    // R8: output stall
    @(negedge clk);
    out_ready = 1'b0;
    send(4'd1, 4'd0, 4'd1, 1'b0, 16'h0123);
    check("R8 valid", 32'(out_valid), 32'd1);
    drive(4'd1, 4'd0, 4'd2, 1'b0, 16'h0456);
    in_valid = 1'b1;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check("R8 stall ready", 32'(in_ready), 32'd0);
      check("R8 hold op0", 32'(out_op0), 32'h0123);
      check("R8 hold valid", 32'(out_valid), 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next packet", 32'(out_op0), 32'h0456);
    @(negedge clk);
    check("R8 drained", 32'(out_valid), 32'd0);

    // R9: reprogram constant
    cfg(4'd3, 1'b1, 1'b1, 16'h0099);
    send(4'd3, 4'd1, 4'd1, 1'b0, 16'h0030);
    check("R9 new const", 32'(out_op1), 32'h0099);

    // R10: reset discards stored tokens and table
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 ready", 32'(in_ready), 32'd1);
    send(4'd5, 4'd0, 4'd0, 1'b1, 16'h0511);
    check("R10 partner gone", 32'(out_valid), 32'd0);
    send(4'd3, 4'd0, 4'd0, 1'b0, 16'h0300);
    check("R10 const cleared", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule